// File: doc/BRIEF.md
# Windowed Kick-Pulse Watchdog Supervisor

This block supervises a processor from the outside. It runs on its own clock and watches one kick pin. A kick is a complete pulse: a rise, a high phase and a fall. A kick counts only when two things hold. Its high time must lie inside a width window. The low time before it must lie inside a spacing window. A single edge, a pin stuck at one level, a glitch, a burst of kicks or a silent pin all count as faults.

On a fault the supervisor records the reason and asserts the processor reset. A mode pin selects what happens next. In the plain mode, reset is held for a fixed hold time. In the cold-start mode, the power-enable output first goes low for a fixed off time, which removes supply through an external switch. Reset then stays asserted for the hold time after power returns. The same hold time is a grace period in which the kick pin is not judged. The grace period also follows the block's own reset. All limits are parameters counted in supervisor clock ticks.

Top module: `kick_supervisor`

## Requirements
- R1: While `rst_n` is low, `rst_out` is 1, `pwr_en` is 1 and `fault_cause` is 00. After `rst_n` rises at a falling clock edge, `rst_out` stays 1 for HOLD_TICKS rising edges. It reads 0 from the falling edge after the HOLD_TICKS-th rising edge.
- R2: The kick pin passes through a two-flop synchronizer. A level driven during one cycle is judged three rising edges later. A fault raises `rst_out` on the edge where it is judged.
- R3: A high phase shorter than W_MIN cycles is a width fault, reported as `fault_cause` = 01 when the pin falls.
- R4: A high phase longer than W_MAX cycles is also a width fault (01). It is reported on the cycle the high phase reaches W_MAX+1, so a lone rising edge never services the supervisor.
- R5: A low phase shorter than S_MIN cycles before a rising edge is a spacing fault, reported as `fault_cause` = 10 at that rise.
- R6: A low phase longer than S_MAX cycles is a timeout fault (11), reported when the low phase reaches S_MAX+1 cycles. The first low phase is counted from the end of the grace period.
- R7: Pulses with width in [W_MIN, W_MAX] and spacing in [S_MIN, S_MAX], both bounds included, keep `rst_out` at 0.
- R8: When `mode_pwr` = 0 at the fault, `pwr_en` stays 1 and `rst_out` stays 1 for exactly HOLD_TICKS cycles.
- R9: When `mode_pwr` = 1 at the fault, `pwr_en` is 0 for exactly OFF_TICKS cycles with `rst_out` held at 1. `rst_out` then stays 1 for HOLD_TICKS more cycles with `pwr_en` at 1.
- R10: Kick activity during the grace period, the power-off time or the reset hold time is ignored. It does not lengthen or shorten them.
- R11: `fault_cause` keeps the reason of the latest fault until the next fault. Only `rst_n` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock, independent of the processor |
| rst_n | input | 1 | Asynchronous active-low reset of the supervisor |
| kick_in | input | 1 | Asynchronous kick pin from the processor |
| mode_pwr | input | 1 | Fault response: 0 reset only, 1 power cycle then reset |
| rst_out | output | 1 | Processor reset, active high |
| pwr_en | output | 1 | Processor power enable, low during the off time |
| fault_cause | output | 2 | Latest fault: 00 none, 01 width, 10 spacing short, 11 timeout |

## Verification
Every result has a known latency. A kick level driven in cycle n is judged at the rising edge n+3. The fault shows on `rst_out` and `fault_cause` at the falling edge that follows. Power stays off for OFF_TICKS cycles, and reset is released HOLD_TICKS cycles after that. The bench counts falling edges from the first cycle in which `rst_out` is low. It computes the edge on which each fault is due from the pulse widths and gaps it applied. It then samples one edge before that point and exactly on it, and does the same at each end of the power-off time and the hold time. A sweep covers every first width, gap and second width around the window bounds in both modes, so each bound is probed on both sides.

// File: rtl/ksup_pkg.sv
package ksup_pkg;

  typedef enum logic [1:0] {
    ST_GRACE   = 2'd0,
    ST_RUN     = 2'd1,
    ST_PWR_OFF = 2'd2
  } sup_state_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'b00,
    CAUSE_WIDTH = 2'b01,
    CAUSE_EARLY = 2'b10,
    CAUSE_LATE  = 2'b11
  } fault_cause_e;

endpackage

// File: rtl/ksup_sync.sv
module ksup_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= async_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/ksup_monitor.sv
module ksup_monitor
  import ksup_pkg::*;
#(
  parameter int unsigned W_MIN = 4,
  parameter int unsigned W_MAX = 64,
  parameter int unsigned S_MIN = 256,
  parameter int unsigned S_MAX = 4096
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         level,
  output logic         fault,
  output fault_cause_e cause
);
  localparam int unsigned TOP = (S_MAX > W_MAX) ? S_MAX : W_MAX;
  localparam int unsigned CW  = $clog2(TOP + 2);
  localparam logic [CW-1:0] W_MIN_C = CW'(W_MIN);
  localparam logic [CW-1:0] W_MAX_C = CW'(W_MAX);
  localparam logic [CW-1:0] S_MIN_C = CW'(S_MIN);
  localparam logic [CW-1:0] S_MAX_C = CW'(S_MAX);
  localparam logic [CW-1:0] ONE_C   = CW'(1);

  logic          prev_q;
  logic [CW-1:0] run_q, run_d;
  logic          rise, fall;

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

  // run_q counts consecutive samples at the current level
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_NONE;
    run_d = run_q;
    if (!enable) begin
      run_d = '0;
    end else if (rise) begin
      run_d = ONE_C;
      if (run_q < S_MIN_C) begin
        fault = 1'b1;
        cause = CAUSE_EARLY;
      end
    end else if (fall) begin
      run_d = ONE_C;
      if (run_q < W_MIN_C) begin
        fault = 1'b1;
        cause = CAUSE_WIDTH;
      end
    end else if (level && run_q >= W_MAX_C) begin
      fault = 1'b1;
      cause = CAUSE_WIDTH;
    end else if (!level && run_q >= S_MAX_C) begin
      fault = 1'b1;
      cause = CAUSE_LATE;
    end else begin
      run_d = run_q + ONE_C;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= '0;
    end else begin
      prev_q <= level;
      run_q  <= run_d;
    end
  end
endmodule

// File: rtl/ksup_sequencer.sv
module ksup_sequencer
  import ksup_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = 1024,
  parameter int unsigned OFF_TICKS  = 32768
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fault,
  input  fault_cause_e cause,
  input  logic         mode_pwr,
  output logic         running,
  output logic         rst_out,
  output logic         pwr_en,
  output logic [1:0]   fault_cause
);
  localparam int unsigned LONGEST = (OFF_TICKS > HOLD_TICKS) ? OFF_TICKS : HOLD_TICKS;
  localparam int unsigned TW      = $clog2(LONGEST + 1);
  localparam logic [TW-1:0] HOLD_M1 = TW'(HOLD_TICKS - 1);
  localparam logic [TW-1:0] OFF_M1  = TW'(OFF_TICKS - 1);

  sup_state_e    state_q;
  logic [TW-1:0] tmr_q;
  fault_cause_e  cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_GRACE;
      tmr_q   <= HOLD_M1;
      cause_q <= CAUSE_NONE;
    end else begin
      case (state_q)
        ST_GRACE: begin
          if (tmr_q == '0) state_q <= ST_RUN;
          else             tmr_q   <= tmr_q - 1'b1;
        end
        ST_RUN: begin
          if (fault) begin
            cause_q <= cause;
            if (mode_pwr) begin
              state_q <= ST_PWR_OFF;
              tmr_q   <= OFF_M1;
            end else begin
              state_q <= ST_GRACE;
              tmr_q   <= HOLD_M1;
            end
          end
        end
        ST_PWR_OFF: begin
          if (tmr_q == '0) begin
            state_q <= ST_GRACE;
            tmr_q   <= HOLD_M1;
          end else begin
            tmr_q <= tmr_q - 1'b1;
          end
        end
        default: begin
          state_q <= ST_GRACE;
          tmr_q   <= HOLD_M1;
        end
      endcase
    end
  end

  assign running     = (state_q == ST_RUN);
  assign rst_out     = (state_q != ST_RUN);
  assign pwr_en      = (state_q != ST_PWR_OFF);
  assign fault_cause = cause_q;
endmodule

// File: rtl/kick_supervisor.sv
module kick_supervisor
  import ksup_pkg::*;
#(
  parameter int unsigned W_MIN      = 4,
  parameter int unsigned W_MAX      = 64,
  parameter int unsigned S_MIN      = 256,
  parameter int unsigned S_MAX      = 4096,
  parameter int unsigned HOLD_TICKS = 1024,
  parameter int unsigned OFF_TICKS  = 32768,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_in,
  input  logic       mode_pwr,
  output logic       rst_out,
  output logic       pwr_en,
  output logic [1:0] fault_cause
);
  logic         kick_lvl;
  logic         running;
  logic         mon_fault;
  fault_cause_e mon_cause;

  ksup_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (kick_in),
    .sync_out (kick_lvl)
  );

  ksup_monitor #(
    .W_MIN (W_MIN),
    .W_MAX (W_MAX),
    .S_MIN (S_MIN),
    .S_MAX (S_MAX)
  ) u_mon (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (running),
    .level  (kick_lvl),
    .fault  (mon_fault),
    .cause  (mon_cause)
  );

  ksup_sequencer #(
    .HOLD_TICKS (HOLD_TICKS),
    .OFF_TICKS  (OFF_TICKS)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .fault       (mon_fault),
    .cause       (mon_cause),
    .mode_pwr    (mode_pwr),
    .running     (running),
    .rst_out     (rst_out),
    .pwr_en      (pwr_en),
    .fault_cause (fault_cause)
  );
endmodule

// File: rtl/ksup_checker.sv
module ksup_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_pwr,
  input logic       rst_out,
  input logic       pwr_en,
  input logic [1:0] fault_cause,
  input logic       mon_fault,
  input logic       running
);
  a_r9_power_off_holds_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_en |-> rst_out);

  a_r9_power_cut_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en) |-> $past(mode_pwr));

  a_r9_reset_after_power_back: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_en) |-> rst_out);

  a_r8_reset_only_keeps_power: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(rst_out) && !$past(mode_pwr)) |-> pwr_en);

  a_r11_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(rst_out) |-> $stable(fault_cause));

  a_r3_fault_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out) |-> (fault_cause != 2'b00));

  a_r10_no_judging_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mon_fault |-> running);

  a_r2_fault_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mon_fault) |=> rst_out);
endmodule

bind kick_supervisor ksup_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_pwr    (mode_pwr),
  .rst_out     (rst_out),
  .pwr_en      (pwr_en),
  .fault_cause (fault_cause),
  .mon_fault   (mon_fault),
  .running     (running)
);

// File: tb/sim_kick_supervisor.sv
`timescale 1ns/1ps
module sim_kick_supervisor;
  localparam int W_MIN = 2;
  localparam int W_MAX = 4;
  localparam int S_MIN = 3;
  localparam int S_MAX = 8;
  localparam int HOLD  = 5;
  localparam int OFF   = 6;
  localparam int LEAD  = S_MIN;      // low cycles driven before first kick
  localparam int L0    = LEAD + 2;   // low samples judged before first kick

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic kick_in = 1'b0;
  logic mode_pwr = 1'b0;
  logic rst_out, pwr_en;
  logic [1:0] fault_cause;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  kick_supervisor #(
    .W_MIN (W_MIN), .W_MAX (W_MAX), .S_MIN (S_MIN), .S_MAX (S_MAX),
    .HOLD_TICKS (HOLD), .OFF_TICKS (OFF), .SYNC_STAGES (2)
  ) u0 (
    .clk (clk), .rst_n (rst_n), .kick_in (kick_in), .mode_pwr (mode_pwr),
    .rst_out (rst_out), .pwr_en (pwr_en), .fault_cause (fault_cause)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Edge index (counted from first low rst_out) at which the fault shows, and its cause
  function automatic void expect_fault(input int w1, input int g, input int w2,
                                       output int k, output int c);
    int b1, b2;
    if (w1 > W_MAX)      begin k = L0 + W_MAX + 1; c = 1; return; end
    if (w1 < W_MIN)      begin k = L0 + w1 + 1;    c = 1; return; end
    b1 = L0 + w1;
    if (g > S_MAX)       begin k = b1 + S_MAX + 1; c = 3; return; end
    if (g < S_MIN)       begin k = b1 + g + 1;     c = 2; return; end
    b2 = b1 + g;
    if (w2 > W_MAX)      begin k = b2 + W_MAX + 1; c = 1; return; end
    if (w2 < W_MIN)      begin k = b2 + w2 + 1;    c = 1; return; end
    k = b2 + w2 + S_MAX + 1; c = 3;
  endfunction

  function automatic logic kick_at(input int n, input int w1, input int g, input int w2,
                                   input int k, input int kend);
    if (n >= k) return (n < kend - 4) ? logic'(n % 2) : 1'b0;
    return ((n >= LEAD && n < LEAD + w1) ||
            (n >= LEAD + w1 + g && n < LEAD + w1 + g + w2));
  endfunction

  task automatic run_case(input int w1, input int g, input int w2, input bit md);
    int k, c, kend;
    expect_fault(w1, g, w2, k, c);
    kend = md ? (k + OFF + HOLD) : (k + HOLD);
    @(negedge clk);
    rst_n = 1'b0; kick_in = 1'b0; mode_pwr = md;
    @(negedge clk);
    chk(rst_out == 1'b1 && pwr_en == 1'b1, "R1 reset outputs", {rst_out, pwr_en}, 3);
    chk(fault_cause == 2'b00, "R1/R11 cause cleared by reset", fault_cause, 0);
    rst_n = 1'b1;
    kick_in = 1'b1;                      // R10: kick toggled during grace
    @(negedge clk);
    kick_in = 1'b0;
    repeat (HOLD - 2) @(negedge clk);
    chk(rst_out == 1'b1, "R1 grace still held", rst_out, 1);
    @(negedge clk);
    chk(rst_out == 1'b0, "R1/R10 grace released on time", rst_out, 0);
    for (int n = 0; n <= kend; n++) begin
      if (n == k - 1) chk(rst_out == 1'b0, "R7 valid kicks keep reset low", rst_out, 0);
      if (n == k) begin
        chk(rst_out == 1'b1, "R2 fault raises reset on due edge", rst_out, 1);
        chk(fault_cause == 2'(c), (c == 1) ? "R3/R4 width cause" :
                                  (c == 2) ? "R5 early cause" : "R6 timeout cause",
            fault_cause, c);
        if (md) chk(pwr_en == 1'b0, "R9 power cut", pwr_en, 0);
        else    chk(pwr_en == 1'b1, "R8 power kept", pwr_en, 1);
      end
      if (md && n == k + OFF - 1) chk(pwr_en == 1'b0, "R9 power off length", pwr_en, 0);
      if (md && n == k + OFF) chk(pwr_en == 1'b1 && rst_out == 1'b1,
                                  "R9 power back with reset held", {pwr_en, rst_out}, 3);
      if (n == kend - 1) chk(rst_out == 1'b1, "R8/R9 hold length", rst_out, 1);
      if (n == kend) begin
        chk(rst_out == 1'b0, "R10 reset released on time despite kicks", rst_out, 0);
        chk(fault_cause == 2'(c), "R11 cause held", fault_cause, c);
      end
      kick_in = kick_at(n, w1, g, w2, k, kend);
      @(negedge clk);
    end
    kick_in = 1'b0;
  endtask

  initial begin
    for (int md = 0; md < 2; md++)
      for (int w1 = 1; w1 <= W_MAX + 1; w1++)
        for (int g = 1; g <= S_MAX + 1; g++)
          for (int w2 = 1; w2 <= W_MAX + 1; w2++)
            run_case(w1, g, w2, md[0]);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule